// File: doc/BRIEF.md
# Virtual Function Capability Register Block

This block holds the register set that a PCI Express physical function exposes to describe and control its single-root virtual functions. Configuration software reaches it through a dword-addressed read/write port with per-byte enables. The block decides which fields software may change and holds the page-size and virtual-function BAR registers. It turns a change of the enable bit into a count of live virtual functions, which the function logic around it uses to instantiate or retire those functions.

The structure sits at a configurable base offset in configuration space and spans thirteen dwords. Offsets relative to the base are: 0x00 control (bit 0 enable, bit 3 memory space enable, bit 4 ARI hierarchy), 0x04 initial count in [15:0] and total count in [31:16], 0x08 requested count in [15:0], 0x0C first-VF offset in [15:0] and stride in [31:16], 0x10 VF device ID in [31:16], 0x14 supported page sizes, 0x18 system page size, and 0x1C through 0x30 six VF BAR dwords. Reads are combinational. A live count change is published one cycle after the control write, together with a one-cycle pulse. Every virtual function's routing ID is produced continuously from the physical function's ID.

Top module: `vfcap_regs`

## Requirements
- R1: A write whose address lies below the base or at/after base+0x34 changes no register. A read there returns 0.
- R2: In the control dword only bits 0, 3 and 4 can be written. Every other bit reads 0.
- R3: The requested-count field (offset 0x08, bits [15:0]) is writable in all 16 bits. The initial count, total count, first-VF offset, stride and device ID read their parameter values, and writes to them are ignored.
- R4: The system page size reads 0x00000001 after reset and after a function reset.
- R5: Supported page sizes reads 0x553 ORed with the optional parameter and is read-only. The system page size accepts writes only in the bits set in that value.
- R6: Setting the enable bit while no VFs are live, with the requested count in 1..TOTAL_VFS, makes the live count equal the requested count. The count changes one clock edge after the write edge, and the pulse is high for exactly that following cycle.
- R7: Setting the enable bit with a requested count of 0 or above TOTAL_VFS leaves the live count at 0, while still giving the one-cycle pulse.
- R8: Clearing the enable bit while VFs are live returns the live count to 0, with the same one-cycle timing and pulse.
- R9: A function reset clears control, requested count and live count, drops any pending change, and restores each VF BAR to its parameter type bits (0 for the upper dword of a 64-bit pair).
- R10: The routing ID of VF n is pf_rid + first-VF offset + n * stride, modulo 2^16, for every n below TOTAL_VFS.
- R11: A 64-bit memory BAR takes writes in both its dwords above its size, with its type bits read-only. A 32-bit memory or I/O BAR takes writes in its one dword above its size. A BAR with size 0 is read-only and reads its type.
- R12: Only bytes whose enable is set are written. A control write takes effect only when byte 0 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_rst | input | 1 | Synchronous function reset, one cycle or longer |
| pf_rid | input | 16 | Routing ID of the physical function |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 12 | Byte address in configuration space (dword aligned) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, 0 outside the structure |
| vf_en | output | 1 | Current enable bit |
| vf_active_cnt | output | 16 | Number of live virtual functions |
| vf_active_vld | output | 1 | One-cycle pulse marking an update of vf_active_cnt |
| vf_rid | output | TOTAL_VFS*16 | Routing ID of VF n in bits [16n+15:16n] |

## Verification
The enable path is driven with a requested count of 3, with exactly TOTAL_VFS, with one past TOTAL_VFS and with zero. This separates a correct upper bound from an off-by-one one and a real bring-up from a stuck count. Removal and a function reset while functions are live show whether the count and the pulse fall at the right edge. Writes of all ones, and writes with single byte lanes enabled, go to each BAR kind, the page-size registers and the requested count; they tell write-mask or byte-lane errors apart from type-bit corruption. Writes to addresses that alias a real register in their low bits, but lie outside the structure, expose an address decode that ignores the base.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;

  localparam int NUM_BARS   = 6;
  localparam int CAP_DWORDS = 13;

  // dword index of each register relative to the capability base
  localparam logic [3:0] DW_CTRL  = 4'd0;
  localparam logic [3:0] DW_COUNT = 4'd1;
  localparam logic [3:0] DW_NUMVF = 4'd2;
  localparam logic [3:0] DW_ROUTE = 4'd3;
  localparam logic [3:0] DW_DEVID = 4'd4;
  localparam logic [3:0] DW_PGSUP = 4'd5;
  localparam logic [3:0] DW_PGSYS = 4'd6;
  localparam logic [3:0] DW_BAR0  = 4'd7;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_MSE_BIT = 3;
  localparam int CTRL_ARI_BIT = 4;
  localparam logic [7:0] CTRL_WMASK =
    8'((1 << CTRL_EN_BIT) | (1 << CTRL_MSE_BIT) | (1 << CTRL_ARI_BIT));

  localparam logic [31:0] PGSZ_MANDATORY = 32'h0000_0553;
  localparam logic [31:0] PGSZ_DEFAULT   = 32'h0000_0001;

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] data;
  } cfg_wbus_t;

  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  // writable address bits of a BAR of 2**log2sz bytes; 0 means not implemented
  function automatic logic [63:0] bar_wmask64(input logic [7:0] log2sz);
    if (log2sz == 8'd0) return 64'd0;
    return ~((64'd1 << log2sz) - 64'd1);
  endfunction

endpackage

// File: rtl/vfcap_ctrl.sv
module vfcap_ctrl
  import vfcap_pkg::*;
#(
  parameter int TOTAL_VFS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        func_rst,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_byte,
  input  logic        num_we,
  input  logic [1:0]  num_be,
  input  logic [15:0] num_wdata,
  output logic [15:0] ctrl_q,
  output logic [15:0] num_q,
  output logic [15:0] active_q,
  output logic        vld_q
);

  localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);

  logic [15:0] ctrl_d, num_d, active_d, pend_cnt_d, pend_cnt_q;
  logic        live_d, live_q, pend_d, pend_q, vld_d;
  logic        ctrl_en, num_en, live_en, act_en;
  logic        new_en, old_en, num_ok, act_up, act_dn;

  // enable-edge detection against the stored bit
  always_comb begin
    new_en = ctrl_byte[CTRL_EN_BIT];
    old_en = ctrl_q[CTRL_EN_BIT];
    num_ok = (num_q != 16'd0) && (num_q <= TOTAL_W);
    act_up = ctrl_we && new_en && !old_en && !live_q;
    act_dn = ctrl_we && !new_en && live_q;
  end

  always_comb begin
    ctrl_en = func_rst || ctrl_we;
    ctrl_d  = func_rst ? 16'd0 : {8'd0, ctrl_byte & CTRL_WMASK};

    num_en = func_rst || num_we;
    num_d  = num_q;
    if (func_rst) begin
      num_d = 16'd0;
    end else begin
      if (num_be[0]) num_d[7:0]  = num_wdata[7:0];
      if (num_be[1]) num_d[15:8] = num_wdata[15:8];
    end

    live_en = func_rst || act_up || act_dn;
    live_d  = !func_rst && act_up && num_ok;

    pend_d     = !func_rst && (act_up || act_dn);
    pend_cnt_d = (act_up && num_ok) ? num_q : 16'd0;

    act_en   = func_rst || pend_q;
    active_d = func_rst ? 16'd0 : pend_cnt_q;
    vld_d    = !func_rst && pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= 16'd0;
      num_q      <= 16'd0;
      live_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_cnt_q <= 16'd0;
      active_q   <= 16'd0;
      vld_q      <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (num_en)  num_q  <= num_d;
      if (live_en) live_q <= live_d;
      pend_q     <= pend_d;
      pend_cnt_q <= pend_cnt_d;
      if (act_en)  active_q <= active_d;
      vld_q      <= vld_d;
    end
  end

endmodule

// File: rtl/vfcap_pgsz.sv
module vfcap_pgsz
  import vfcap_pkg::*;
#(
  parameter logic [31:0] SUPPORTED = PGSZ_MANDATORY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        func_rst,
  input  logic        we,
  input  cfg_wbus_t   wbus,
  output logic [31:0] sys_q
);

  logic [31:0] wmask, sys_d;
  logic        sys_en;

  always_comb begin
    wmask  = SUPPORTED & be_to_mask(wbus.be);
    sys_en = func_rst || we;
    sys_d  = func_rst ? PGSZ_DEFAULT : ((sys_q & ~wmask) | (wbus.data & wmask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sys_q <= PGSZ_DEFAULT;
    else if (sys_en) sys_q <= sys_d;
  end

endmodule

// File: rtl/vfcap_bars.sv
module vfcap_bars
  import vfcap_pkg::*;
#(
  parameter logic [NUM_BARS*32-1:0] BAR_TYPE = '0,
  parameter logic [NUM_BARS*8-1:0]  BAR_LOG2 = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     func_rst,
  input  logic [NUM_BARS-1:0]      we,
  input  cfg_wbus_t                wbus,
  output logic [NUM_BARS*32-1:0]   bar_q
);

  function automatic logic [7:0] lg(input int i);
    return BAR_LOG2[i*8 +: 8];
  endfunction

  function automatic logic is_mem64(input int i);
    logic [31:0] t;
    t = BAR_TYPE[i*32 +: 32];
    return !t[0] && (t[2:1] == 2'b10) && (lg(i) != 8'd0);
  endfunction

  function automatic logic is_upper(input int i);
    if (i == 0) return 1'b0;
    return is_mem64(i - 1);
  endfunction

  function automatic logic [31:0] mask_of(input int i);
    logic [63:0] m;
    if (is_upper(i)) begin
      m = bar_wmask64(lg(i - 1));
      return m[63:32];
    end
    m = bar_wmask64(lg(i));
    return m[31:0];
  endfunction

  function automatic logic [31:0] init_of(input int i);
    if (is_upper(i)) return 32'd0;
    return BAR_TYPE[i*32 +: 32] & ~mask_of(i);
  endfunction

  logic [31:0] bemask;
  assign bemask = be_to_mask(wbus.be);

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    localparam logic [31:0] WMASK = mask_of(g);
    localparam logic [31:0] INIT  = init_of(g);

    logic [31:0] q, d, m;
    logic        en;

    always_comb begin
      m  = WMASK & bemask;
      en = func_rst || we[g];
      d  = func_rst ? INIT : ((q & ~m) | (wbus.data & m));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= INIT;
      else if (en) q <= d;
    end

    assign bar_q[g*32 +: 32] = q;
  end

endmodule

// File: rtl/vfcap_rid.sv
module vfcap_rid #(
  parameter int          TOTAL_VFS = 8,
  parameter logic [15:0] VF_OFFSET = 16'h0080,
  parameter logic [15:0] VF_STRIDE = 16'h0002
) (
  input  logic [15:0]             pf_rid,
  output logic [TOTAL_VFS*16-1:0] vf_rid
);

  logic [15:0] first_rid;
  assign first_rid = pf_rid + VF_OFFSET;

  for (genvar n = 0; n < TOTAL_VFS; n++) begin : g_vf
    localparam logic [15:0] STEP = 16'(n) * VF_STRIDE;
    assign vf_rid[n*16 +: 16] = first_rid + STEP;
  end

endmodule

// File: rtl/vfcap_regs.sv
module vfcap_regs
  import vfcap_pkg::*;
#(
  parameter logic [11:0]            CAP_BASE    = 12'h160,
  parameter int                     TOTAL_VFS   = 8,
  parameter int                     INITIAL_VFS = 8,
  parameter logic [15:0]            VF_OFFSET   = 16'h0080,
  parameter logic [15:0]            VF_STRIDE   = 16'h0002,
  parameter logic [15:0]            VF_DEVID    = 16'h10CA,
  parameter logic [31:0]            PGSZ_OPT    = 32'h0000_0000,
  parameter logic [NUM_BARS*32-1:0] BAR_TYPE    =
    {32'h0, 32'h1, 32'h0, 32'h4, 32'h0, 32'h0},
  parameter logic [NUM_BARS*8-1:0]  BAR_LOG2    =
    {8'd0, 8'd5, 8'd0, 8'd20, 8'd0, 8'd12}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     func_rst,
  input  logic [15:0]              pf_rid,
  input  logic                     cfg_wr,
  input  logic [11:0]              cfg_addr,
  input  logic [3:0]               cfg_be,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic                     vf_en,
  output logic [15:0]              vf_active_cnt,
  output logic                     vf_active_vld,
  output logic [TOTAL_VFS*16-1:0]  vf_rid
);

  localparam logic [31:0] PGSZ_SUP  = PGSZ_MANDATORY | PGSZ_OPT;
  localparam logic [11:0] CAP_BYTES = 12'(CAP_DWORDS * 4);
  localparam logic [15:0] TOTAL_W   = 16'(TOTAL_VFS);
  localparam logic [15:0] INIT_W    = 16'(INITIAL_VFS);

  logic [11:0]         rel;
  logic [3:0]          dw;
  logic                in_rng, wr_hit;
  logic                ctrl_we, num_we, pg_we;
  logic [NUM_BARS-1:0] bar_we;
  cfg_wbus_t           wbus;

  logic [15:0]            ctrl_q, num_q;
  logic [31:0]            sys_q;
  logic [NUM_BARS*32-1:0] bar_q;

  // address decode
  always_comb begin
    rel     = cfg_addr - CAP_BASE;
    in_rng  = (cfg_addr >= CAP_BASE) && (rel < CAP_BYTES);
    dw      = rel[5:2];
    wr_hit  = cfg_wr && in_rng;
    ctrl_we = wr_hit && (dw == DW_CTRL) && cfg_be[0];
    num_we  = wr_hit && (dw == DW_NUMVF) && (cfg_be[1:0] != 2'b00);
    pg_we   = wr_hit && (dw == DW_PGSYS);
    for (int b = 0; b < NUM_BARS; b++)
      bar_we[b] = wr_hit && (dw == 4'(DW_BAR0 + 4'(b)));
    wbus.be   = cfg_be;
    wbus.data = cfg_wdata;
  end

  vfcap_ctrl #(
    .TOTAL_VFS (TOTAL_VFS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_rst  (func_rst),
    .ctrl_we   (ctrl_we),
    .ctrl_byte (cfg_wdata[7:0]),
    .num_we    (num_we),
    .num_be    (cfg_be[1:0]),
    .num_wdata (cfg_wdata[15:0]),
    .ctrl_q    (ctrl_q),
    .num_q     (num_q),
    .active_q  (vf_active_cnt),
    .vld_q     (vf_active_vld)
  );

  vfcap_pgsz #(
    .SUPPORTED (PGSZ_SUP)
  ) u_pgsz (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_rst (func_rst),
    .we       (pg_we),
    .wbus     (wbus),
    .sys_q    (sys_q)
  );

  vfcap_bars #(
    .BAR_TYPE (BAR_TYPE),
    .BAR_LOG2 (BAR_LOG2)
  ) u_bars (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_rst (func_rst),
    .we       (bar_we),
    .wbus     (wbus),
    .bar_q    (bar_q)
  );

  vfcap_rid #(
    .TOTAL_VFS (TOTAL_VFS),
    .VF_OFFSET (VF_OFFSET),
    .VF_STRIDE (VF_STRIDE)
  ) u_rid (
    .pf_rid (pf_rid),
    .vf_rid (vf_rid)
  );

  // read mux
  always_comb begin
    cfg_rdata = 32'd0;
    if (in_rng) begin
      case (dw)
        DW_CTRL:  cfg_rdata = {16'd0, ctrl_q};
        DW_COUNT: cfg_rdata = {TOTAL_W, INIT_W};
        DW_NUMVF: cfg_rdata = {16'd0, num_q};
        DW_ROUTE: cfg_rdata = {VF_STRIDE, VF_OFFSET};
        DW_DEVID: cfg_rdata = {VF_DEVID, 16'd0};
        DW_PGSUP: cfg_rdata = PGSZ_SUP;
        DW_PGSYS: cfg_rdata = sys_q;
        default: begin
          for (int b = 0; b < NUM_BARS; b++)
            if (dw == 4'(DW_BAR0 + 4'(b))) cfg_rdata = bar_q[b*32 +: 32];
        end
      endcase
    end
  end

  assign vf_en = ctrl_q[CTRL_EN_BIT];

endmodule

// File: rtl/vfcap_regs_chk.sv
module vfcap_regs_chk #(
  parameter logic [11:0] CAP_BASE  = 12'h160,
  parameter int          TOTAL_VFS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        func_rst,
  input logic [11:0] cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        vf_en,
  input logic [15:0] vf_active_cnt,
  input logic        vf_active_vld
);

  localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);

  // R1: nothing below the base answers a read
  a_r1_below_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < CAP_BASE) |-> (cfg_rdata == 32'd0));

  // R2: reserved control bits never read as one
  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == CAP_BASE) |-> ((cfg_rdata & ~32'h0000_0019) == 32'd0));

  // R6: the live count never exceeds the total
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    vf_active_cnt <= TOTAL_W);

  // R6: the live count only moves on a pulse cycle or after a function reset
  a_r6_cnt_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!vf_active_vld && !$past(func_rst)) |-> $stable(vf_active_cnt));

  // R8: once the enable bit falls the count is zero one edge later
  a_r8_fall_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vf_en) |=> (vf_active_cnt == 16'd0));

  // R9: function reset leaves nothing live and no pulse
  a_r9_func_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(func_rst) |-> (vf_active_cnt == 16'd0 && !vf_en && !vf_active_vld));

endmodule

bind vfcap_regs vfcap_regs_chk #(
  .CAP_BASE  (CAP_BASE),
  .TOTAL_VFS (TOTAL_VFS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .func_rst      (func_rst),
  .cfg_addr      (cfg_addr),
  .cfg_rdata     (cfg_rdata),
  .vf_en         (vf_en),
  .vf_active_cnt (vf_active_cnt),
  .vf_active_vld (vf_active_vld)
);

// File: tb/test_vfcap_regs.sv
module test_vfcap_regs;

  localparam logic [11:0] BASE  = 12'h160;
  localparam int          NVF   = 8;
  localparam int          NVEC  = 40;

  logic          clk;
  logic          rst_n;
  logic          func_rst;
  logic [15:0]   pf_rid;
  logic          cfg_wr;
  logic [11:0]   cfg_addr;
  logic [3:0]    cfg_be;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          vf_en;
  logic [15:0]   vf_active_cnt;
  logic          vf_active_vld;
  logic [NVF*16-1:0] vf_rid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  vfcap_regs i_vfcap_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .func_rst      (func_rst),
    .pf_rid        (pf_rid),
    .cfg_wr        (cfg_wr),
    .cfg_addr      (cfg_addr),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .vf_en         (vf_en),
    .vf_active_cnt (vf_active_cnt),
    .vf_active_vld (vf_active_vld),
    .vf_rid        (vf_rid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // reads check exp; writes carry exp = 0
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h04, 4'hF, 32'h0,        32'h0008_0008, 4'd3},  // R3 counts
    '{1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd3},
    '{1'b0, 8'h04, 4'hF, 32'h0,        32'h0008_0008, 4'd3},  // R3 read-only
    '{1'b1, 8'h0C, 4'hF, 32'h1234_5678, 32'h0,        4'd3},
    '{1'b0, 8'h0C, 4'hF, 32'h0,        32'h0002_0080, 4'd3},  // R3 offset/stride
    '{1'b1, 8'h10, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd3},
    '{1'b0, 8'h10, 4'hF, 32'h0,        32'h10CA_0000, 4'd3},  // R3 device ID
    '{1'b0, 8'h14, 4'hF, 32'h0,        32'h0000_0553, 4'd5},  // R5 supported
    '{1'b1, 8'h14, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd5},
    '{1'b0, 8'h14, 4'hF, 32'h0,        32'h0000_0553, 4'd5},  // R5 read-only
    '{1'b0, 8'h18, 4'hF, 32'h0,        32'h0000_0001, 4'd4},  // R4 default
    '{1'b1, 8'h18, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd5},
    '{1'b0, 8'h18, 4'hF, 32'h0,        32'h0000_0553, 4'd5},  // R5 sys mask
    '{1'b1, 8'h18, 4'hF, 32'h0000_0010, 32'h0,        4'd5},
    '{1'b0, 8'h18, 4'hF, 32'h0,        32'h0000_0010, 4'd5},  // R5 pick size
    '{1'b1, 8'h08, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd3},
    '{1'b0, 8'h08, 4'hF, 32'h0,        32'h0000_FFFF, 4'd3},  // R3 all 16 bits
    '{1'b1, 8'h08, 4'h1, 32'h0000_0005, 32'h0,        4'd12},
    '{1'b0, 8'h08, 4'hF, 32'h0,        32'h0000_FF05, 4'd12}, // R12 byte lane
    '{1'b1, 8'h1C, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h1C, 4'hF, 32'h0,        32'hFFFF_F000, 4'd11}, // R11 mem32
    '{1'b1, 8'h1C, 4'h1, 32'h0,        32'h0,         4'd11},
    '{1'b0, 8'h1C, 4'hF, 32'h0,        32'hFFFF_F000, 4'd11}, // R11 low bits ro
    '{1'b1, 8'h1C, 4'h2, 32'h0,        32'h0,         4'd12},
    '{1'b0, 8'h1C, 4'hF, 32'h0,        32'hFFFF_0000, 4'd12}, // R12 byte 1 only
    '{1'b1, 8'h20, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h20, 4'hF, 32'h0,        32'h0000_0000, 4'd11}, // R11 unimplemented
    '{1'b1, 8'h24, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h24, 4'hF, 32'h0,        32'hFFF0_0004, 4'd11}, // R11 mem64 low
    '{1'b1, 8'h28, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h28, 4'hF, 32'h0,        32'hFFFF_FFFF, 4'd11}, // R11 mem64 high
    '{1'b1, 8'h2C, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h2C, 4'hF, 32'h0,        32'hFFFF_FFE1, 4'd11}, // R11 io
    '{1'b1, 8'h34, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd1},
    '{1'b0, 8'h34, 4'hF, 32'h0,        32'h0000_0000, 4'd1},  // R1 past end
    '{1'b1, 8'h48, 4'hF, 32'h0000_1234, 32'h0,        4'd1},
    '{1'b0, 8'h08, 4'hF, 32'h0,        32'h0000_FF05, 4'd1},  // R1 no alias
    '{1'b1, 8'h00, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd2},
    '{1'b0, 8'h00, 4'hF, 32'h0,        32'h0000_0019, 4'd2},  // R2 ctrl mask
    '{1'b1, 8'h00, 4'hE, 32'h0,        32'h0,         4'd12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
  endtask

  task automatic cfg_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #2;
    check(req, cfg_rdata, exp);
  endtask

  task automatic pulse_frst();
    @(negedge clk); func_rst = 1'b1;
    @(negedge clk); func_rst = 1'b0;
  endtask

  // write the control dword, then verify count and pulse timing
  task automatic enable_step(input logic [31:0] ctrl, input logic [15:0] exp_cnt,
                             input logic [15:0] old_cnt, input string req);
    cfg_write(BASE, 4'hF, ctrl);
    check({req, " no pulse yet"}, {31'd0, vf_active_vld}, 32'd0);
    check({req, " count not yet"}, {16'd0, vf_active_cnt}, {16'd0, old_cnt});
    @(negedge clk);
    check({req, " pulse"}, {31'd0, vf_active_vld}, 32'd1);
    check({req, " count"}, {16'd0, vf_active_cnt}, {16'd0, exp_cnt});
    @(negedge clk);
    check({req, " pulse ends"}, {31'd0, vf_active_vld}, 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; func_rst = 1'b0; pf_rid = 16'h0100;
    cfg_wr = 1'b0; cfg_addr = 12'h0; cfg_be = 4'h0; cfg_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: R4 R9
    check("R9 reset vf_en", {31'd0, vf_en}, 32'd0);
    check("R9 reset count", {16'd0, vf_active_cnt}, 32'd0);
    check("R9 reset pulse", {31'd0, vf_active_vld}, 32'd0);
    cfg_read(BASE + 12'h24, 32'h0000_0004, "R9 reset BAR2 type");
    cfg_read(BASE + 12'h2C, 32'h0000_0001, "R9 reset BAR4 type");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) cfg_write(BASE + 12'(VEC[i].off), VEC[i].be, VEC[i].data);
      else cfg_read(BASE + 12'(VEC[i].off), VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].req, i));
    end
    cfg_read(BASE, 32'h0000_0019, "R12 ctrl untouched without byte 0");
    cfg_write(BASE, 4'hF, 32'h0);

    // R1: outside addresses that alias real registers in their low bits
    cfg_write(12'h008, 4'hF, 32'h0000_0077);
    cfg_write(BASE - 12'h4, 4'hF, 32'hFFFF_FFFF);
    cfg_read(BASE + 12'h08, 32'h0000_FF05, "R1 below base ignored");
    cfg_read(12'h008, 32'h0, "R1 read below base");
    cfg_read(BASE + 12'h34, 32'h0, "R1 read past end");

    // R9: function reset restores the defaults
    pulse_frst();
    cfg_read(BASE, 32'h0, "R9 ctrl cleared");
    cfg_read(BASE + 12'h08, 32'h0, "R9 requested count cleared");
    cfg_read(BASE + 12'h18, 32'h0000_0001, "R4 sys page after func reset");
    cfg_read(BASE + 12'h1C, 32'h0, "R9 BAR0 type");
    cfg_read(BASE + 12'h24, 32'h0000_0004, "R9 BAR2 type");
    cfg_read(BASE + 12'h28, 32'h0, "R9 BAR3 upper");
    cfg_read(BASE + 12'h2C, 32'h0000_0001, "R9 BAR4 type");

    // R6 then R8
    cfg_write(BASE + 12'h08, 4'hF, 32'h3);
    enable_step(32'h1, 16'd3, 16'd0, "R6 enable 3");
    check("R6 vf_en", {31'd0, vf_en}, 32'd1);
    enable_step(32'h0, 16'd0, 16'd3, "R8 disable");

    // R7: above total, and zero
    cfg_write(BASE + 12'h08, 4'hF, 32'h9);
    enable_step(32'h1, 16'd0, 16'd0, "R7 count above total");
    cfg_write(BASE, 4'hF, 32'h0);
    @(negedge clk);
    check("R7 no pulse on idle disable", {31'd0, vf_active_vld}, 32'd0);
    cfg_write(BASE + 12'h08, 4'hF, 32'h0);
    enable_step(32'h1, 16'd0, 16'd0, "R7 count zero");
    cfg_write(BASE, 4'hF, 32'h0);

    // R6 boundary: exactly the total
    cfg_write(BASE + 12'h08, 4'hF, 32'h8);
    enable_step(32'h19, 16'd8, 16'd0, "R6 enable total");

    // R10: routing IDs
    for (int n = 0; n < NVF; n++)
      check($sformatf("R10 rid vf%0d", n), {16'd0, vf_rid[n*16 +: 16]},
            {16'd0, 16'h0100 + 16'h0080 + 16'(n * 2)});
    pf_rid = 16'hFFF0;
    #1;
    check("R10 rid wrap vf7", {16'd0, vf_rid[7*16 +: 16]}, 32'h0000_007E);

    // R9: function reset while live
    pulse_frst();
    check("R9 count after func reset", {16'd0, vf_active_cnt}, 32'd0);
    check("R9 vf_en after func reset", {31'd0, vf_en}, 32'd0);
    @(negedge clk);
    check("R9 no pulse after func reset", {31'd0, vf_active_vld}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule